// File: doc/BRIEF.md
# Banked SPI Register Access Controller

This block sits on the host side of an SPI link to a peripheral whose control registers are split into four banks. The host hands it one register operation at a time: read, write, bit-set or bit-clear, with a 7-bit register identifier that packs a bank number together with a 5-bit address. A separate flag marks registers that belong to the MAC or PHY group. The controller frames the operation as SPI bytes, drives chip select, SCLK and MOSI, samples MISO, and reports completion with a one-cycle done strobe that carries the byte read back.

The bank is chosen by the two low bits of the peripheral's control-1 register at address 0x1F. The controller keeps its own copy of that bank number. When a request targets a banked address in a different bank, it first runs the bank-switch transactions on its own. The top five addresses are present in every bank and never cause a switch. Direct host accesses to control-1 are watched so that the copy stays correct.

Requests enter through a valid/ready handshake. The controller takes one request at a time: `req_ready` is high only while it is idle, and a request held valid while the controller is busy simply waits. The response side has no back-pressure. `rsp_valid` pulses for one cycle and `rsp_rdata` then holds its value until the next completion.

Top module: `banked_spi_regctl`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sclk` is low, `req_ready` is high, `busy` is low and `rsp_valid` is low.
- R2: Every command byte carries the opcode in bits 7:5 and the register address in bits 4:0. The opcodes are read 000, write 010, bit-set 100 and bit-clear 101. The `req_op` encoding is 0 read, 1 write, 2 bit-set, 3 bit-clear. In `req_reg`, bits 4:0 are the address and bits 6:5 the bank.
- R3: A write, bit-set or bit-clear is one chip-select assertion of two bytes: the command byte, then the data byte.
- R4: An ordinary read is one chip-select assertion of the command byte followed by a 0x00 byte. The byte received during the second byte appears on `rsp_rdata` when `rsp_valid` pulses.
- R5: A read with `req_macphy` set clocks a third byte of 0x00 in the same assertion and returns the byte received during that third byte. For non-read operations `req_macphy` has no effect.
- R6: A bank change comes before the requested transaction. It is a bit-clear of mask 0x03 on address 0x1F (bytes 0xBF, 0x03), followed by a bit-set of the bank number on 0x1F (0x9F, bank) only when the new bank is nonzero. Each of these is a separate chip-select assertion.
- R7: After reset the bank copy is unknown, so the first banked access performs the switch sequence even when it targets bank 0.
- R8: A banked access to the bank already held in the copy issues no switch transactions. A completed switch loads the copy with the new bank.
- R9: Accesses to addresses 0x1B to 0x1F never cause a bank switch, whatever the bank field holds. They leave the bank copy unchanged, except as described in R10.
- R10: A completed host access to address 0x1F updates the bank copy. A write loads data bits 1:0. A read loads bits 1:0 of the returned byte. A bit-set or bit-clear applies its mask bits 1:0 to a known copy, and a full mask of 0x03 defines the copy even when it is unknown.
- R11: `req_ready` is high only while idle. `busy` is high from the cycle after acceptance through the cycle of `rsp_valid`, and `rsp_valid` lasts exactly one cycle. A request held valid right after a completion is accepted once the controller is idle again.
- R12: SPI mode 0 is used: SCLK idles low and never pulses while chip select is high, MOSI is sent MSB first, and each SCLK half period lasts `CLK_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 bit-set, 3 bit-clear |
| req_reg | input | 7 | Register identifier: bank in 6:5, address in 4:0 |
| req_wdata | input | 8 | Write data or bit mask |
| req_macphy | input | 1 | Register is in the MAC/PHY group (extra dummy byte on reads) |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Read byte (0 after non-read operations) |
| busy | output | 1 | Operation in progress |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to peripheral |
| spi_miso | input | 1 | Serial data from peripheral |

## Verification
Two things can land on the same cycle boundary. One is the bank-copy update from a completing access to control-1. The other is the switch decision for a request that has been held valid and is accepted on the very next idle cycle. The bench provokes this by presenting a direct write of a new bank to 0x1F and then, with `req_valid` never dropped, a banked write to that same bank. It judges the result from the chip-select framed byte log of a behavioural SPI target: the second request must appear as a single transaction with no clear or set ahead of it.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

  localparam int ADDR_W = 5;
  localparam int BANK_W = 2;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } reg_op_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] addr;
  } reg_id_t;

  typedef enum logic [1:0] {
    PH_CLR  = 2'd0,
    PH_SET  = 2'd1,
    PH_MAIN = 2'd2
  } phase_e;

  localparam logic [2:0] OPC_READ  = 3'b000;
  localparam logic [2:0] OPC_WRITE = 3'b010;
  localparam logic [2:0] OPC_SET   = 3'b100;
  localparam logic [2:0] OPC_CLEAR = 3'b101;

  localparam logic [ADDR_W-1:0] SHARED_LO  = 5'h1B;
  localparam logic [ADDR_W-1:0] CTRL1_ADDR = 5'h1F;
  localparam logic [BYTE_W-1:0] BANK_MASK  = 8'h03;

  function automatic logic [2:0] opcode_of(reg_op_e op);
    case (op)
      OP_READ:  return OPC_READ;
      OP_WRITE: return OPC_WRITE;
      OP_SET:   return OPC_SET;
      default:  return OPC_CLEAR;
    endcase
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       active,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] div_cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       sh_tx;
  logic [7:0]       sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      done    <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          sh_tx   <= tx_byte;
          div_cnt <= '0;
          bit_idx <= '0;
          sclk    <= 1'b0;
        end
      end else if (div_cnt == CNT_LAST) begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          sh_rx <= {sh_rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_idx == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 3'd1;
            sh_tx   <= {sh_tx[6:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + CNT_W'(1);
      end
    end
  end

  assign mosi    = active & sh_tx[7];
  assign rx_byte = sh_rx;

  p_start_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
  p_sclk_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sclk);

endmodule

// File: rtl/bank_cache.sv
module bank_cache
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_done,
  input  logic [BANK_W-1:0] sw_bank,
  input  logic              snoop_en,
  input  reg_op_e           snoop_op,
  input  logic [BANK_W-1:0] snoop_wbits,
  input  logic [BANK_W-1:0] snoop_rbits,
  output logic              known,
  output logic [BANK_W-1:0] bank
);
  localparam logic [BANK_W-1:0] FULL = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      known <= 1'b0;
      bank  <= '0;
    end else if (sw_done) begin
      known <= 1'b1;
      bank  <= sw_bank;
    end else if (snoop_en) begin
      case (snoop_op)
        OP_WRITE: begin known <= 1'b1; bank <= snoop_wbits; end
        OP_READ:  begin known <= 1'b1; bank <= snoop_rbits; end
        OP_SET: begin
          if (known) bank <= bank | snoop_wbits;
          else if (snoop_wbits == FULL) begin known <= 1'b1; bank <= FULL; end
        end
        default: begin
          if (known) bank <= bank & ~snoop_wbits;
          else if (snoop_wbits == FULL) begin known <= 1'b1; bank <= '0; end
        end
      endcase
    end
  end

  p_switch_learn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done |=> known && (bank == $past(sw_bank)));
  p_one_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_done && snoop_en));

endmodule

// File: rtl/txn_sequencer.sv
module txn_sequencer
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [6:0]        req_reg,
  input  logic [7:0]        req_wdata,
  input  logic              req_macphy,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  output logic              busy,
  output logic              cs_n,
  output logic              sh_start,
  output logic [7:0]        sh_tx,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  input  logic              cache_known,
  input  logic [BANK_W-1:0] cache_bank,
  output logic              sw_done,
  output logic [BANK_W-1:0] sw_bank,
  output logic              snoop_en,
  output reg_op_e           snoop_op,
  output logic [BANK_W-1:0] snoop_wbits,
  output logic [BANK_W-1:0] snoop_rbits
);
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_GAP} state_e;

  state_e     state;
  phase_e     phase;
  logic [1:0] idx;
  reg_op_e    op_q;
  reg_id_t    id_q;
  logic [7:0] wdata_q;
  logic       macphy_q;
  logic [7:0] rdata_q;

  reg_id_t    id_in;
  logic       need_switch;
  logic [1:0] last_idx;

  assign id_in = reg_id_t'(req_reg);
  assign need_switch = (id_in.addr < SHARED_LO) &&
                       (!cache_known || (cache_bank != id_in.bank));
  assign last_idx = (phase == PH_MAIN && op_q == OP_READ && macphy_q) ? 2'd2 : 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= PH_MAIN;
      idx      <= '0;
      op_q     <= OP_READ;
      id_q     <= '0;
      wdata_q  <= '0;
      macphy_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            op_q     <= reg_op_e'(req_op);
            id_q     <= id_in;
            wdata_q  <= req_wdata;
            macphy_q <= req_macphy;
            phase    <= need_switch ? PH_CLR : PH_MAIN;
            idx      <= '0;
            state    <= ST_LEAD;
          end
        end
        ST_LEAD: state <= ST_SHIFT;
        ST_SHIFT: begin
          if (sh_done) begin
            if (idx == last_idx) begin
              state <= ST_GAP;
              if (phase == PH_MAIN) rdata_q <= (op_q == OP_READ) ? sh_rx : 8'h00;
            end else begin
              idx   <= idx + 2'd1;
              state <= ST_LEAD;
            end
          end
        end
        default: begin
          idx <= '0;
          case (phase)
            PH_CLR: begin
              phase <= (id_q.bank != '0) ? PH_SET : PH_MAIN;
              state <= ST_LEAD;
            end
            PH_SET: begin
              phase <= PH_MAIN;
              state <= ST_LEAD;
            end
            default: state <= ST_IDLE;
          endcase
        end
      endcase
    end
  end

  always_comb begin
    sh_tx = 8'h00;
    case (phase)
      PH_CLR:  sh_tx = (idx == 2'd0) ? {OPC_CLEAR, CTRL1_ADDR} : BANK_MASK;
      PH_SET:  sh_tx = (idx == 2'd0) ? {OPC_SET, CTRL1_ADDR} : {{(8-BANK_W){1'b0}}, id_q.bank};
      default: begin
        if (idx == 2'd0)          sh_tx = {opcode_of(op_q), id_q.addr};
        else if (op_q != OP_READ) sh_tx = wdata_q;
      end
    endcase
  end

  assign req_ready   = (state == ST_IDLE);
  assign busy        = (state != ST_IDLE);
  assign cs_n        = !(state == ST_LEAD || state == ST_SHIFT);
  assign sh_start    = (state == ST_LEAD);
  assign rsp_valid   = (state == ST_GAP) && (phase == PH_MAIN);
  assign rsp_rdata   = rdata_q;
  assign sw_done     = (state == ST_GAP) &&
                       (phase == PH_SET || (phase == PH_CLR && id_q.bank == '0));
  assign sw_bank     = id_q.bank;
  assign snoop_en    = rsp_valid && (id_q.addr == CTRL1_ADDR);
  assign snoop_op    = op_q;
  assign snoop_wbits = wdata_q[BANK_W-1:0];
  assign snoop_rbits = rdata_q[BANK_W-1:0];

  p_done_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);
  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_shared_noswitch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LEAD && phase != PH_MAIN) |-> (id_q.addr < SHARED_LO));
  p_cs_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && sh_done && idx == last_idx) |=> cs_n);

endmodule

// File: rtl/banked_spi_regctl.sv
module banked_spi_regctl
  import spireg_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_op,
  input  logic [6:0] req_reg,
  input  logic [7:0] req_wdata,
  input  logic       req_macphy,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic       busy,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic              sh_start, sh_done, sh_active;
  logic [7:0]        sh_tx, sh_rx;
  logic              cache_known;
  logic [BANK_W-1:0] cache_bank;
  logic              sw_done;
  logic [BANK_W-1:0] sw_bank;
  logic              snoop_en;
  reg_op_e           snoop_op;
  logic [BANK_W-1:0] snoop_wbits, snoop_rbits;

  txn_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_reg     (req_reg),
    .req_wdata   (req_wdata),
    .req_macphy  (req_macphy),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .busy        (busy),
    .cs_n        (spi_cs_n),
    .sh_start    (sh_start),
    .sh_tx       (sh_tx),
    .sh_done     (sh_done),
    .sh_rx       (sh_rx),
    .cache_known (cache_known),
    .cache_bank  (cache_bank),
    .sw_done     (sw_done),
    .sw_bank     (sw_bank),
    .snoop_en    (snoop_en),
    .snoop_op    (snoop_op),
    .snoop_wbits (snoop_wbits),
    .snoop_rbits (snoop_rbits)
  );

  spi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .active  (sh_active),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  bank_cache u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_done     (sw_done),
    .sw_bank     (sw_bank),
    .snoop_en    (snoop_en),
    .snoop_op    (snoop_op),
    .snoop_wbits (snoop_wbits),
    .snoop_rbits (snoop_rbits),
    .known       (cache_known),
    .bank        (cache_bank)
  );

  p_sclk_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  p_shift_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_active |-> !spi_cs_n);

endmodule

// File: tb/tb_banked_spi_regctl.sv
`timescale 1ns/1ps
module tb_banked_spi_regctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'd0;
  logic [6:0] req_reg = '0;
  logic [7:0] req_wdata = '0;
  logic       req_macphy = 1'b0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       busy;
  logic       spi_cs_n, spi_sclk, spi_mosi;
  logic       spi_miso = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  banked_spi_regctl #(.CLK_DIV(2)) dut (.*);

  // behavioural SPI target: logs each chip-select frame
  logic [7:0] log_b [64][4];
  int         log_len [64];
  int         log_cnt = 0;
  int         log_base = 0;
  int         sl_bit = 0;
  int         sl_nbytes = 0;
  int         sclk_bad = 0;
  logic [7:0] sl_sh = '0;
  time        rise_t = 0;
  time        hi_w = 0;

  function automatic logic [7:0] resp_of(int k);
    case (k)
      0: return 8'hFF;
      1: return 8'hA5;
      2: return 8'h3C;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge spi_cs_n) begin
    sl_bit = 0;
    sl_nbytes = 0;
    spi_miso = resp_of(0)[7];
  end

  always @(posedge spi_sclk) begin
    rise_t = $time;
    if (spi_cs_n) sclk_bad++;
    else begin
      sl_sh = {sl_sh[6:0], spi_mosi};
      sl_bit++;
      if (sl_bit % 8 == 0) begin
        if (sl_nbytes < 4) log_b[log_cnt & 63][sl_nbytes] = sl_sh;
        sl_nbytes++;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (spi_cs_n === 1'b0) begin
      logic [7:0] nb;
      hi_w = $time - rise_t;
      nb = resp_of(sl_bit / 8);
      spi_miso = nb[7 - (sl_bit % 8)];
    end
  end

  always @(posedge spi_cs_n) begin
    log_len[log_cnt & 63] = sl_nbytes;
    log_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic mark();
    log_base = log_cnt;
  endtask

  task automatic check_count(input int n, input string tag);
    check((log_cnt - log_base) == n, {tag, " frame count"}, log_cnt - log_base, n);
  endtask

  task automatic check_txn(input int k, input int len, input logic [7:0] b0,
                           input logic [7:0] b1, input logic [7:0] b2, input string tag);
    int i;
    i = (log_base + k) & 63;
    check(log_len[i] == len, {tag, " frame length"}, log_len[i], len);
    check(log_b[i][0] == b0, {tag, " byte0"}, log_b[i][0], b0);
    check(log_b[i][1] == b1, {tag, " byte1"}, log_b[i][1], b1);
    if (len > 2) check(log_b[i][2] == b2, {tag, " byte2"}, log_b[i][2], b2);
  endtask

  task automatic do_req(input logic [1:0] op, input logic [6:0] rg, input logic [7:0] wd,
                        input logic mp, output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_reg = rg; req_wdata = wd; req_macphy = mp;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !req_ready, "R11 busy after accept", {busy, req_ready}, 2'b10);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    @(negedge clk);
    check(!rsp_valid && !busy && req_ready, "R11 single pulse", {rsp_valid, busy, req_ready}, 3'b001);
  endtask

  task automatic t_reset();
    check(spi_cs_n && !spi_sclk && req_ready && !busy && !rsp_valid,
          "R1 reset state", {spi_cs_n, spi_sclk, req_ready, busy, rsp_valid}, 5'b10100);
  endtask

  task automatic t_first_bank0();
    logic [7:0] rd;
    mark();
    do_req(2'd1, 7'h05, 8'h5A, 1'b0, rd);
    check_count(2, "R7 first access bank0");
    check_txn(0, 2, 8'hBF, 8'h03, 8'h00, "R6 clear bank");
    check_txn(1, 2, 8'h45, 8'h5A, 8'h00, "R3 write frame");
    check(hi_w == 8, "R12 sclk high width ns", int'(hi_w), 8);
  endtask

  task automatic t_same_bank();
    logic [7:0] rd;
    mark();
    do_req(2'd1, 7'h06, 8'h11, 1'b0, rd);
    check_count(1, "R8 same bank");
    check_txn(0, 2, 8'h46, 8'h11, 8'h00, "R8 write frame");
  endtask

  task automatic t_switch_bank2();
    logic [7:0] rd;
    mark();
    do_req(2'd2, 7'h45, 8'h81, 1'b0, rd);
    check_count(3, "R6 switch to bank2");
    check_txn(0, 2, 8'hBF, 8'h03, 8'h00, "R6 clear");
    check_txn(1, 2, 8'h9F, 8'h02, 8'h00, "R6 set");
    check_txn(2, 2, 8'h85, 8'h81, 8'h00, "R2 set opcode");
    check(rd == 8'h00, "R4 rdata after non-read", rd, 0);
  endtask

  task automatic t_reads();
    logic [7:0] rd;
    mark();
    do_req(2'd0, 7'h47, 8'hEE, 1'b0, rd);
    check_count(1, "R4 plain read");
    check_txn(0, 2, 8'h07, 8'h00, 8'h00, "R4 read frame");
    check(rd == 8'hA5, "R4 read data", rd, 8'hA5);
    mark();
    do_req(2'd0, 7'h4A, 8'h00, 1'b1, rd);
    check_count(1, "R5 macphy read");
    check_txn(0, 3, 8'h0A, 8'h00, 8'h00, "R5 macphy frame");
    check(rd == 8'h3C, "R5 macphy data", rd, 8'h3C);
    mark();
    do_req(2'd3, 7'h4B, 8'h0F, 1'b1, rd);
    check_count(1, "R5 macphy clear");
    check_txn(0, 2, 8'hAB, 8'h0F, 8'h00, "R5 macphy flag ignored");
  endtask

  task automatic t_shared();
    logic [7:0] rd;
    mark();
    do_req(2'd2, 7'h7B, 8'h40, 1'b0, rd);
    check_count(1, "R9 shared no switch");
    check_txn(0, 2, 8'h9B, 8'h40, 8'h00, "R9 shared frame");
    mark();
    do_req(2'd0, 7'h47, 8'h00, 1'b0, rd);
    check_count(1, "R9 copy unchanged");
  endtask

  task automatic t_snoop();
    logic [7:0] rd;
    mark();
    do_req(2'd1, 7'h1F, 8'h01, 1'b0, rd);
    do_req(2'd1, 7'h22, 8'h77, 1'b0, rd);
    check_count(2, "R10 write snoop");
    check_txn(0, 2, 8'h5F, 8'h01, 8'h00, "R10 direct write");
    check_txn(1, 2, 8'h42, 8'h77, 8'h00, "R10 bank1 no switch");
    mark();
    do_req(2'd3, 7'h1F, 8'h01, 1'b0, rd);
    do_req(2'd1, 7'h03, 8'h33, 1'b0, rd);
    check_count(2, "R10 clear snoop");
    check_txn(1, 2, 8'h43, 8'h33, 8'h00, "R10 bank0 no switch");
    mark();
    do_req(2'd0, 7'h1F, 8'h00, 1'b0, rd);
    do_req(2'd1, 7'h24, 8'h55, 1'b0, rd);
    check_count(2, "R10 read snoop");
    check_txn(1, 2, 8'h44, 8'h55, 8'h00, "R10 bank1 from read");
  endtask

  task automatic t_back_to_back();
    int dones;
    dones = 0;
    mark();
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_reg = 7'h1F; req_wdata = 8'h02; req_macphy = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_reg = 7'h44; req_wdata = 8'h99;
    while (!req_ready) begin
      if (rsp_valid) dones++;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    while (dones < 2) begin
      if (rsp_valid) dones++;
      @(negedge clk);
    end
    check_count(2, "R11 back-to-back");
    check_txn(0, 2, 8'h5F, 8'h02, 8'h00, "R10 direct bank2");
    check_txn(1, 2, 8'h44, 8'h99, 8'h00, "R11 held request no switch");
    check(sclk_bad == 0, "R12 sclk with cs high", sclk_bad, 0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_bank0();
    t_same_bank();
    t_switch_bank2();
    t_reads();
    t_shared();
    t_snoop();
    t_back_to_back();
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      report();
      $finish;
    end
  end

endmodule